// File: doc/BRIEF.md
# Walking-One Link Test Packet Generator

This block sits in the network adapter of an on-chip network and produces the test traffic used to find shorted wires on data links. A single start command makes it send one framed packet over a flit-wide output with a valid/ready handshake. The packet opens with a header flit, carries one payload flit per data wire, and closes with a tail flit. In each payload flit exactly one wire is high, and that wire moves up by one position with every flit.

The header carries the destination address, a packet-kind code and the number of the test step. A full test period has two steps, each with one packet. The generator flags the end of each packet with a one-cycle done pulse that also reports the step number. Every adapter in the network launches its packet at the same instant, so the header always appears a fixed single cycle after the start command. The block ignores start commands while a packet is still in flight. A new packet may start in the same cycle as the done pulse, so the two steps can run back to back.

Top module: `wone_pkt_gen`

## Requirements
- R1: While reset is held and directly after it, `valid_o` and `done_o` are low.
- R2: A `start_i` seen while `valid_o` is low makes `valid_o` high, with the header flit on `flit_o`, on the next clock cycle. No other delay is possible.
- R3: Header flit layout: bits [9:8] = 2'b10, bits [7:4] = destination, bits [3:2] = kind, bit [1] = step, bit [0] = 0. The fields are taken from `dest_i`, `kind_i` and `step_i` in the cycle the start is accepted, and later changes to those inputs have no effect.
- R4: After the header come exactly 10 payload flits, in order. Payload flit k (k = 0..9) has only bit k set.
- R5: The tail flit follows the last payload flit. Its bits [9:8] = 2'b01, and bits [7:0] are the same as header bits [7:0]. A packet is always 12 flits long.
- R6: A flit moves on only in a cycle where both `valid_o` and `ready_i` are high. While `ready_i` is low, `flit_o` and the payload position stay unchanged.
- R7: `done_o` is high for exactly one cycle: the cycle after the tail flit is accepted. `valid_o` is low in that cycle, and `done_step_o` gives the step bit of the finished packet.
- R8: A `start_i` seen while `valid_o` is high is ignored, including in the cycle the tail is accepted. The packet in flight does not change, and no further packet follows.
- R9: A `start_i` seen in the cycle where `done_o` is high is accepted, so the next step's header appears in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to launch one test packet |
| dest_i | input | 4 | Destination address for the header |
| kind_i | input | 2 | Packet-kind code for the header |
| step_i | input | 1 | Test-step number (0 or 1) |
| ready_i | input | 1 | Downstream can accept the current flit |
| flit_o | output | 10 | Current flit |
| valid_o | output | 1 | `flit_o` holds a flit of a packet in flight |
| done_o | output | 1 | One-cycle pulse after the tail flit is accepted |
| done_step_o | output | 1 | Step number of the packet that just finished |

## Verification
Two pairs of events can fall in the same cycle. The first is the tail handshake together with a new start. The bench raises `start_i` in the cycle the tail is accepted and expects that packet to finish normally, with no second header afterwards. The second is the done pulse together with a new start. In the back-to-back test the next step's start is driven in the cycle `done_o` is high, and the new header must appear one cycle later with its own fields. Back-pressure patterns that range from no stall to long stalls confirm that each flit stays in place while it waits.

// File: rtl/wone_pkg.sv
package wone_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_PAY  = 2'd2,
        ST_TAIL = 2'd3
    } wone_state_e;

    localparam logic [1:0] MARK_HEAD = 2'b10;
    localparam logic [1:0] MARK_TAIL = 2'b01;

endpackage

// File: rtl/wone_seq_ctrl.sv
module wone_seq_ctrl
    import wone_pkg::*;
#(
    parameter int FLIT_W = 10,
    parameter int ADDR_W = 4,
    parameter int KIND_W = 2,
    localparam int IDX_W = $clog2(FLIT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] dest_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              step_i,
    input  logic              ready_i,
    output wone_state_e       state_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] dest_o,
    output logic [KIND_W-1:0] kind_o,
    output logic              step_o,
    output logic              done_o,
    output logic              done_step_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FLIT_W - 1);

    typedef struct packed {
        wone_state_e       state;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] dest;
        logic [KIND_W-1:0] kind;
        logic              step;
        logic              done;
        logic              done_step;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state = ST_HEAD;
                    ctl_d.dest  = dest_i;
                    ctl_d.kind  = kind_i;
                    ctl_d.step  = step_i;
                end
            end
            ST_HEAD: begin
                if (ready_i) begin
                    ctl_d.state = ST_PAY;
                    ctl_d.idx   = '0;
                end
            end
            ST_PAY: begin
                if (ready_i) begin
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.state = ST_TAIL;
                    end else begin
                        ctl_d.idx = ctl_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_TAIL: begin
                if (ready_i) begin
                    ctl_d.state     = ST_IDLE;
                    ctl_d.done      = 1'b1;
                    ctl_d.done_step = ctl_q.step;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o     = ctl_q.state;
    assign idx_o       = ctl_q.idx;
    assign dest_o      = ctl_q.dest;
    assign kind_o      = ctl_q.kind;
    assign step_o      = ctl_q.step;
    assign done_o      = ctl_q.done;
    assign done_step_o = ctl_q.done_step;

endmodule

// File: rtl/wone_flit_fmt.sv
module wone_flit_fmt
    import wone_pkg::*;
#(
    parameter int FLIT_W = 10,
    parameter int ADDR_W = 4,
    parameter int KIND_W = 2,
    localparam int IDX_W = $clog2(FLIT_W),
    localparam int BODY_W = FLIT_W - 2,
    localparam int RSV_W = BODY_W - ADDR_W - KIND_W - 1
) (
    input  wone_state_e       state_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] dest_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              step_i,
    output logic [FLIT_W-1:0] flit_o,
    output logic              valid_o
);

    logic [FLIT_W-1:0] walk_bits;
    logic [BODY_W-1:0] body;

    for (genvar g = 0; g < FLIT_W; g++) begin : g_walk
        assign walk_bits[g] = (idx_i == IDX_W'(g));
    end

    assign body = {dest_i, kind_i, step_i, {RSV_W{1'b0}}};

    always_comb begin
        unique case (state_i)
            ST_HEAD: flit_o = {MARK_HEAD, body};
            ST_PAY:  flit_o = walk_bits;
            ST_TAIL: flit_o = {MARK_TAIL, body};
            default: flit_o = '0;
        endcase
    end

    assign valid_o = (state_i != ST_IDLE);

endmodule

// File: rtl/wone_pkt_gen.sv
module wone_pkt_gen
    import wone_pkg::*;
#(
    parameter int FLIT_W = 10,
    parameter int ADDR_W = 4,
    parameter int KIND_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] dest_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              step_i,
    input  logic              ready_i,
    output logic [FLIT_W-1:0] flit_o,
    output logic              valid_o,
    output logic              done_o,
    output logic              done_step_o
);

    localparam int IDX_W = $clog2(FLIT_W);

    wone_state_e       state;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] dest;
    logic [KIND_W-1:0] kind;
    logic              step;

    wone_seq_ctrl #(
        .FLIT_W(FLIT_W),
        .ADDR_W(ADDR_W),
        .KIND_W(KIND_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dest_i     (dest_i),
        .kind_i     (kind_i),
        .step_i     (step_i),
        .ready_i    (ready_i),
        .state_o    (state),
        .idx_o      (idx),
        .dest_o     (dest),
        .kind_o     (kind),
        .step_o     (step),
        .done_o     (done_o),
        .done_step_o(done_step_o)
    );

    wone_flit_fmt #(
        .FLIT_W(FLIT_W),
        .ADDR_W(ADDR_W),
        .KIND_W(KIND_W)
    ) fmt_i (
        .state_i(state),
        .idx_i  (idx),
        .dest_i (dest),
        .kind_i (kind),
        .step_i (step),
        .flit_o (flit_o),
        .valid_o(valid_o)
    );

endmodule

// File: rtl/wone_pkt_gen_chk.sv
module wone_pkt_gen_chk #(
    parameter int FLIT_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              ready_i,
    input logic [FLIT_W-1:0] flit_o,
    input logic              valid_o,
    input logic              done_o
);

    // R2
    launch_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i) |=> (valid_o && flit_o[FLIT_W-1 -: 2] == 2'b10));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(flit_o)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_o && ready_i && flit_o[FLIT_W-1 -: 2] == 2'b01));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o);

endmodule

bind wone_pkt_gen wone_pkt_gen_chk #(.FLIT_W(FLIT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .ready_i(ready_i),
    .flit_o (flit_o),
    .valid_o(valid_o),
    .done_o (done_o)
);

// File: tb/wone_pkt_gen_tb_top.sv
module wone_pkt_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] dest_i = '0;
    logic [1:0] kind_i = '0;
    logic       step_i = 1'b0;
    logic       ready_i = 1'b0;
    logic [9:0] flit_o;
    logic       valid_o;
    logic       done_o;
    logic       done_step_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2ns clk = ~clk;

    wone_pkt_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dest_i     (dest_i),
        .kind_i     (kind_i),
        .step_i     (step_i),
        .ready_i    (ready_i),
        .flit_o     (flit_o),
        .valid_o    (valid_o),
        .done_o     (done_o),
        .done_step_o(done_step_o)
    );

    // {expected header[9:0], dest[3:0], kind[1:0], step, ready mask[15:0]}
    localparam logic [32:0] VEC [4] = '{
        {10'h200, 4'h0, 2'd0, 1'b0, 16'hFFFF},
        {10'h25A, 4'h5, 2'd2, 1'b1, 16'hAAAA},
        {10'h2FC, 4'hF, 2'd3, 1'b0, 16'h8421},
        {10'h2A6, 4'hA, 2'd1, 1'b1, 16'h7FFE}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_pkt(input logic [32:0] v, input bit chain, input bit post);
        logic [9:0]  hdr = v[32:23];
        logic [15:0] mask = v[15:0];
        logic [9:0]  exp;
        string       tag;
        int          e = 0;
        int          c = 0;
        bit          stalled = 0;
        bit          r;
        if (!chain) @(negedge clk);
        else chk(done_o == 1'b1, "R9", 32'(done_o), 32'd1);
        chk(!valid_o, chain ? "R9" : "R2", 32'(valid_o), 32'd0);
        start_i = 1'b1;
        dest_i  = v[22:19];
        kind_i  = v[18:17];
        step_i  = v[16];
        ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(valid_o, "R2", 32'(valid_o), 32'd1);
        dest_i = ~dest_i;
        kind_i = ~kind_i;
        step_i = ~step_i;
        while (e < 12) begin
            if (e == 0) exp = hdr;
            else if (e == 11) exp = {2'b01, hdr[7:0]};
            else exp = 10'(1) << (e - 1);
            if (stalled) tag = "R6";
            else if (e == 0) tag = chain ? "R9" : "R3";
            else if (e == 11) tag = "R5";
            else tag = "R4";
            chk(valid_o && flit_o == exp, tag, {21'd0, valid_o, flit_o}, {21'd0, 1'b1, exp});
            r = mask[c % 16];
            ready_i = r;
            // R8: spurious starts mid-packet and in the tail-accept cycle
            start_i = (c == 2) || (r && e == 11);
            @(negedge clk);
            stalled = !r;
            if (r) e++;
            c++;
        end
        ready_i = 1'b0;
        start_i = 1'b0;
        chk(done_o && done_step_o == v[16] && !valid_o, "R7",
            {29'd0, done_o, done_step_o, valid_o}, {29'd0, 1'b1, v[16], 1'b0});
        if (post) begin
            @(negedge clk);
            chk(!done_o, "R7", 32'(done_o), 32'd0);
            chk(!valid_o, "R8", 32'(valid_o), 32'd0);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog R7 actual=%0d expected=<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!valid_o && !done_o, "R1", {30'd0, valid_o, done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_o && !done_o, "R1", {30'd0, valid_o, done_o}, 32'd0);

        for (int i = 0; i < 4; i++) begin
            run_pkt(VEC[i], 1'b0, 1'b1);
        end

        // R9: two steps back to back, second start in the done cycle
        run_pkt(VEC[1], 1'b0, 1'b0);
        run_pkt(VEC[2], 1'b1, 1'b1);

        // R1: reset in the middle of a packet
        @(negedge clk);
        start_i = 1'b1;
        ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!valid_o && !done_o, "R1", {30'd0, valid_o, done_o}, 32'd0);
        rst_n = 1'b1;
        ready_i = 1'b0;
        @(negedge clk);
        chk(!valid_o, "R1", 32'(valid_o), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule